// File: doc/BRIEF.md
# Paired-Channel Memory Copy Engine

This block copies a block of words from one memory region to another without processor involvement. The copy is split into two independent channels. A read channel fetches elements from memory and pushes them into an internal FIFO. A write channel pops elements from that FIFO and stores them at its own addresses. Each channel walks memory with its own start address, element counts and signed strides. It can run a flat (1D) sequence or a row-by-row (2D) pattern, where a second stride is applied between rows.

Software sets up each channel through a small write-only register port. Channel select is bit 3 of the register address: 0 is the read channel and 1 is the write channel. Bits 2:0 select the register:

| Select | Register |
|---|---|
| 0 | start address |
| 1 | row length (count of elements in a row) |
| 2 | element stride, signed 16 bits |
| 3 | row count |
| 4 | row stride, signed 16 bits |
| 5 | configuration |
| 6 | status clear |

Writing the configuration register with the enable bit set starts the channel. Completion and interrupt state can be seen on the status outputs and on the interrupt line. Both channels share one memory request port. A request completes in the cycle in which it is granted. For a read, the data is taken from `mem_rdata` in that same cycle.

Top module: `mdma_pair`

## Requirements
- R1: The read channel reads element k at start + k*stride and pushes the data into the FIFO. The write channel writes the popped data, in order, to its own start + k*stride. Strides are signed 16-bit byte offsets.
- R2: Writing configuration with enable=1 latches the start address, counts and strides into working state. Register writes made while the channel runs do not change the addresses or the number of elements of that transfer.
- R3: The FIFO holds DEPTH words, 8 by default. The read channel issues no request while the FIFO is full. The write channel issues no request while the FIFO is empty.
- R4: In 2D mode (configuration bit 4), after the last element of a row the address advances by the row stride instead of the element stride, and the row length reloads. The transfer moves row length × row count elements.
- R5: After its last element a channel stops by itself. Status bit 2 (running) clears and bit 0 (done) sets, both visible right after the clock edge on which the last access was granted.
- R6: Configuration bit 5 enables the completion interrupt of a channel. Status bit 1 sets on completion only when it is enabled. `irq` is high while either channel's status bit 1 is set.
- R7: In 2D mode with bit 5 and bit 6 (row interrupt) set, status bit 1 also sets at the end of every row.
- R8: Writing the status register clears done where bit 0 of the data is 1 and clears the interrupt bit where bit 1 is 1. Data bits that are 0 leave the matching status bits unchanged. When no interrupt bit is left set, `irq` drops.
- R9: A row length of 0, or a row count of 0 in 2D mode, completes at once. Done sets, and the interrupt bit sets if enabled, with no memory access.
- R10: Configuration bit 1 gives the channel's direction: 0 means it reads memory, 1 means it writes memory. An enable whose direction does not match the channel's role is ignored.
- R11: `mem_size` carries configuration bits 3:2 of the channel that owns the current request. The values are 0 for byte, 1 for halfword and 2 for word.
- R12: When both channels can issue a request, the write channel is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | bit 3 channel, bits 2:0 register select |
| reg_wdata | input | 32 | register write data |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write (write channel), 0 = read |
| mem_addr | output | 32 | byte address of the access |
| mem_size | output | 2 | element size of the access |
| mem_wdata | output | 32 | write data (FIFO head) |
| mem_gnt | input | 1 | access completes this cycle |
| mem_rdata | input | 32 | read data, valid in the grant cycle |
| irq | output | 1 | interrupt, OR of the channel interrupt bits |
| src_status | output | 3 | read channel {running, irq, done} |
| dst_status | output | 3 | write channel {running, irq, done} |

## Verification
The hardest state to reach from the ports is a full FIFO. While the write channel runs, it takes the port whenever the FIFO holds data, so the read channel rarely gets more than one word ahead. The stimulus starts the read channel alone, lets it fill all DEPTH entries and stall, and checks that the request line goes low before the write channel is enabled to drain the FIFO. Row interrupts, register rewrites during a transfer and mismatched directions are each driven by their own configuration sequences. Random grant gaps make the two channels interleave irregularly.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_XLEN  = 3'd1,
        SEL_XSTEP = 3'd2,
        SEL_YLEN  = 3'd3,
        SEL_YSTEP = 3'd4,
        SEL_CFG   = 3'd5,
        SEL_CLR   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic       row_irq;
        logic       irq_en;
        logic       two_d;
        logic [1:0] size;
        logic       writes;
        logic       enable;
    } cfg_t;

    typedef struct packed {
        logic running;
        logic irq;
        logic done;
    } stat_t;

    function automatic logic [AW-1:0] advance(logic [AW-1:0] a, logic [15:0] m);
        return a + {{(AW-16){m[15]}}, m};
    endfunction
endpackage

// File: rtl/mdma_fifo.sv
module mdma_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [FW-1:0]    fill
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wp, rp;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign dout  = store[rp];
    assign full  = (fill == FW'(DEPTH));
    assign empty = (fill == '0);
endmodule

// File: rtl/mdma_chan.sv
module mdma_chan
    import mdma_pkg::*;
#(
    parameter bit IS_DST = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          step,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic [1:0]    cur_size,
    output stat_t         stat
);
    logic [AW-1:0] r_start;
    logic [15:0]   r_xlen, r_xstep, r_ylen, r_ystep;

    logic [AW-1:0] w_addr;
    logic [15:0]   w_xcnt, w_ycnt, w_xlen, w_xstep, w_ystep;
    logic [1:0]    w_size;
    logic          w_irq_en, w_row_irq;
    stat_t         st;

    cfg_t new_cfg;
    logic go, zero_len;

    assign new_cfg  = cfg_t'(wr_data[6:0]);
    assign go       = wr_en && (wr_sel == SEL_CFG) && new_cfg.enable
                      && (new_cfg.writes == IS_DST) && !st.running;
    assign zero_len = (r_xlen == '0) || (new_cfg.two_d && (r_ylen == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            r_start <= '0; r_xlen <= '0; r_xstep <= '0; r_ylen <= '0; r_ystep <= '0;
            w_addr <= '0; w_xcnt <= '0; w_ycnt <= '0; w_xlen <= '0;
            w_xstep <= '0; w_ystep <= '0; w_size <= '0;
            w_irq_en <= 1'b0; w_row_irq <= 1'b0;
            st <= '0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    SEL_START: r_start <= wr_data;
                    SEL_XLEN:  r_xlen  <= wr_data[15:0];
                    SEL_XSTEP: r_xstep <= wr_data[15:0];
                    SEL_YLEN:  r_ylen  <= wr_data[15:0];
                    SEL_YSTEP: r_ystep <= wr_data[15:0];
                    SEL_CLR: begin
                        if (wr_data[0]) st.done <= 1'b0;
                        if (wr_data[1]) st.irq  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (go) begin
                if (zero_len) begin
                    st.done <= 1'b1;
                    if (new_cfg.irq_en) st.irq <= 1'b1;
                end else begin
                    st.running <= 1'b1;
                    w_addr     <= r_start;
                    w_xcnt     <= r_xlen;
                    w_xlen     <= r_xlen;
                    w_ycnt     <= new_cfg.two_d ? r_ylen : 16'd1;
                    w_xstep    <= r_xstep;
                    w_ystep    <= r_ystep;
                    w_size     <= new_cfg.size;
                    w_irq_en   <= new_cfg.irq_en;
                    w_row_irq  <= new_cfg.row_irq & new_cfg.two_d;
                end
            end
            if (step && st.running) begin
                if (w_xcnt != 16'd1) begin
                    w_addr <= advance(w_addr, w_xstep);
                    w_xcnt <= w_xcnt - 1'b1;
                end else if (w_ycnt != 16'd1) begin
                    w_addr <= advance(w_addr, w_ystep);
                    w_xcnt <= w_xlen;
                    w_ycnt <= w_ycnt - 1'b1;
                    if (w_irq_en && w_row_irq) st.irq <= 1'b1;
                end else begin
                    st.running <= 1'b0;
                    st.done    <= 1'b1;
                    if (w_irq_en) st.irq <= 1'b1;
                end
            end
        end
    end

    assign busy     = st.running;
    assign cur_addr = w_addr;
    assign cur_size = w_size;
    assign stat     = st;
endmodule

// File: rtl/mdma_pair.sv
module mdma_pair
    import mdma_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq,
    output logic [2:0]    src_status,
    output logic [2:0]    dst_status
);
    logic          ch_busy [2];
    logic [AW-1:0] ch_addr [2];
    logic [1:0]    ch_size [2];
    stat_t         ch_stat [2];
    logic          ch_step [2];

    logic          fifo_full, fifo_empty;
    logic [FW-1:0] fifo_fill;
    logic          rd_want, wr_want;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        mdma_chan #(.IS_DST(c == 1)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_wr && (reg_addr[3] == 1'(c))),
            .wr_sel   (reg_addr[2:0]),
            .wr_data  (reg_wdata),
            .step     (ch_step[c]),
            .busy     (ch_busy[c]),
            .cur_addr (ch_addr[c]),
            .cur_size (ch_size[c]),
            .stat     (ch_stat[c])
        );
    end

    assign rd_want = ch_busy[0] && !fifo_full;
    assign wr_want = ch_busy[1] && !fifo_empty;

    assign mem_req  = rd_want || wr_want;
    assign mem_we   = wr_want;
    assign mem_addr = wr_want ? ch_addr[1] : ch_addr[0];
    assign mem_size = wr_want ? ch_size[1] : ch_size[0];

    assign ch_step[1] = wr_want && mem_gnt;
    assign ch_step[0] = rd_want && !wr_want && mem_gnt;

    mdma_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (ch_step[0]),
        .pop   (ch_step[1]),
        .din   (mem_rdata),
        .dout  (mem_wdata),
        .full  (fifo_full),
        .empty (fifo_empty),
        .fill  (fifo_fill)
    );

    assign src_status = ch_stat[0];
    assign dst_status = ch_stat[1];
    assign irq        = ch_stat[0].irq || ch_stat[1].irq;
endmodule

// File: rtl/mdma_pair_chk.sv
module mdma_pair_chk #(
    parameter int DEPTH = 8,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [2:0]    src_status,
    input logic [2:0]    dst_status,
    input logic [FW-1:0] fill
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));

    assert_read_room_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (fill < FW'(DEPTH)));

    assert_write_data_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (fill != '0));

    assert_pop_count_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_gnt) |=> (fill == $past(fill) - 1'b1));

    assert_src_stop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(src_status[2]) |-> src_status[0]);

    assert_dst_stop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(dst_status[2]) |-> dst_status[0]);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!src_status[2] && !dst_status[2]) |-> !mem_req);

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(dst_status[1]) |-> ($past(reg_wr) && ($past(reg_addr) == 4'hE) && $past(reg_wdata[1])));
endmodule

bind mdma_pair mdma_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .src_status (src_status),
    .dst_status (dst_status),
    .fill       (fifo_fill)
);

// File: tb/tb_mdma_pair.sv
`timescale 1ns/1ps
module tb_mdma_pair;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_gnt, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic [2:0]  src_status, dst_status;

    always #2.5 clk = ~clk;

    mdma_pair #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq),
        .src_status(src_status), .dst_status(dst_status)
    );

    // memory model: read data derived from the address
    assign mem_rdata = {mem_addr[15:0], ~mem_addr[15:0]};

    logic [7:0] lfsr = 8'h5B;
    bit gnt_rand = 1'b0;
    bit gnt_hold = 1'b0;
    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign mem_gnt = !gnt_hold && (!gnt_rand || lfsr[0]);

    int chks = 0, errs = 0;
    bit finished = 1'b0;

    logic [31:0] sexp[$], dexp[$], dq[$];
    int sfill = 0, n_acc = 0;
    int src_size = 0, dst_size = 0;
    int d_k = 0, d_row = 0, d_total = 0;
    bit d_rowirq = 1'b0, row_pend = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model compared on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (row_pend) begin
                check(dst_status[1] == 1'b1, "R7", "row interrupt bit", dst_status[1], 1);
                row_pend = 1'b0;
            end
            if (mem_req && mem_gnt) begin
                n_acc++;
                if (!mem_we) begin
                    check(!(dst_status[2] && sfill > 0), "R12", "read served while write pending", sfill, 0);
                    check(sexp.size() > 0, "R1", "unexpected read", mem_addr, 0);
                    if (sexp.size() > 0) begin
                        logic [31:0] ea;
                        ea = sexp.pop_front();
                        check(mem_addr == ea, "R1", "read address", mem_addr, ea);
                    end
                    check(mem_size == 2'(src_size), "R11", "read size", mem_size, src_size);
                    dq.push_back(mem_rdata);
                    sfill++;
                    check(sfill <= DEPTH, "R3", "fifo occupancy", sfill, DEPTH);
                end else begin
                    check(dexp.size() > 0, "R1", "unexpected write", mem_addr, 0);
                    if (dexp.size() > 0) begin
                        logic [31:0] ea;
                        ea = dexp.pop_front();
                        check(mem_addr == ea, "R4", "write address", mem_addr, ea);
                    end
                    check(mem_size == 2'(dst_size), "R11", "write size", mem_size, dst_size);
                    if (dq.size() > 0) begin
                        logic [31:0] ed;
                        ed = dq.pop_front();
                        check(mem_wdata == ed, "R1", "write data", mem_wdata, ed);
                    end else check(1'b0, "R3", "write with empty fifo", sfill, 1);
                    sfill--;
                    d_k++;
                    if (d_rowirq && (d_k % d_row == 0) && d_k < d_total) row_pend = 1'b1;
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] cfgv(bit en, bit w, int size, bit twod, bit ie, bit row);
        return 32'(en) | (32'(w) << 1) | (32'(size) << 2) | (32'(twod) << 4) | (32'(ie) << 5) | (32'(row) << 6);
    endfunction

    task automatic chan(bit dst, logic [31:0] start, int x, int xm, int y, int ym,
                        bit w, int size, bit twod, bit ie, bit row);
        logic [3:0] b;
        logic [31:0] a;
        int rows;
        b = dst ? 4'h8 : 4'h0;
        wr(b | 4'd0, start);
        wr(b | 4'd1, 32'(x));
        wr(b | 4'd2, 32'(xm & 16'hFFFF));
        wr(b | 4'd3, 32'(y));
        wr(b | 4'd4, 32'(ym & 16'hFFFF));
        rows = twod ? y : 1;
        if ((w == dst) && x != 0 && rows != 0) begin
            a = start;
            for (int r = 0; r < rows; r++) begin
                for (int k = 0; k < x; k++) begin
                    if (dst) dexp.push_back(a); else sexp.push_back(a);
                    a = a + ((k == x - 1) ? ym : xm);
                end
            end
            if (dst) begin
                dst_size = size; d_k = 0; d_row = x; d_total = x * rows; d_rowirq = ie && row && twod;
            end else src_size = size;
        end
        wr(b | 4'd5, cfgv(1'b1, w, size, twod, ie, row));
    endtask

    task automatic wait_done(bit dst, string req);
        int t;
        t = 0;
        while (!(dst ? dst_status[0] : src_status[0]) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, req, "completion timeout", t, 5000);
        @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", chks, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(mem_req == 1'b0, "R5", "reset mem_req", mem_req, 0);
        check(irq == 1'b0, "R6", "reset irq", irq, 0);
        check(src_status == 3'b000, "R5", "reset src status", src_status, 0);
        check(dst_status == 3'b000, "R5", "reset dst status", dst_status, 0);

        // 1D word copy, interrupt only on the write channel
        chan(0, 32'h100, 5, 4, 0, 0, 0, 2, 0, 0, 0);
        chan(1, 32'h800, 5, 4, 0, 0, 1, 2, 0, 1, 0);
        wait_done(1, "R1");
        check(src_status == 3'b001, "R6", "src status no irq", src_status, 3'b001);
        check(dst_status == 3'b011, "R5", "dst done+irq, stopped", dst_status, 3'b011);
        check(irq == 1'b1, "R6", "irq high", irq, 1);
        check(sexp.size() == 0 && dexp.size() == 0, "R1", "all elements moved", sexp.size() + dexp.size(), 0);

        // write-one-to-clear
        wr(4'hE, 32'h0);
        @(negedge clk);
        check(dst_status == 3'b011, "R8", "zero write keeps bits", dst_status, 3'b011);
        wr(4'hE, 32'h2);
        @(negedge clk);
        check(dst_status == 3'b001, "R8", "irq bit cleared", dst_status, 3'b001);
        check(irq == 1'b0, "R8", "irq line dropped", irq, 0);
        wr(4'hE, 32'h1);
        wr(4'h6, 32'h3);
        @(negedge clk);
        check(dst_status == 3'b000 && src_status == 3'b000, "R8", "done cleared",
              {src_status, dst_status}, 0);

        // 2D both sides, mixed size on writes, row interrupts, random grant gaps
        gnt_rand = 1'b1;
        chan(0, 32'h1000, 3, 4, 4, 32, 0, 2, 1, 0, 0);
        chan(1, 32'h1800, 4, 2, 3, 10, 1, 1, 1, 1, 1);
        wait_done(1, "R4");
        wait_done(0, "R4");
        check(dexp.size() == 0 && sexp.size() == 0, "R4", "2D element count", dexp.size() + sexp.size(), 0);
        check(dst_status == 3'b011, "R7", "2D done with irq", dst_status, 3'b011);
        wr(4'hE, 32'h3);
        wr(4'h6, 32'h3);

        // fill the FIFO with the read channel alone, then drain with negative stride
        gnt_rand = 1'b0;
        chan(0, 32'h2000, 12, 4, 0, 0, 0, 2, 0, 0, 0);
        repeat (30) @(negedge clk);
        check(mem_req == 1'b0, "R3", "read stalls on full fifo", mem_req, 0);
        check(sfill == DEPTH, "R3", "fifo filled", sfill, DEPTH);
        check(src_status[2] == 1'b1, "R3", "read channel still running", src_status[2], 1);
        chan(1, 32'h3000, 12, -4, 0, 0, 1, 2, 0, 1, 0);
        wait_done(1, "R3");
        check(dexp.size() == 0, "R1", "negative stride drained", dexp.size(), 0);
        wr(4'hE, 32'h3);
        wr(4'h6, 32'h3);

        // register writes during a running transfer
        gnt_hold = 1'b1;
        base = n_acc;
        chan(0, 32'h4000, 3, 4, 0, 0, 0, 2, 0, 0, 0);
        chan(1, 32'h5000, 3, 4, 0, 0, 1, 2, 0, 1, 0);
        wr(4'h0, 32'h9000);
        wr(4'h1, 32'd7);
        wr(4'h8, 32'hAAAA);
        wr(4'h9, 32'd9);
        gnt_hold = 1'b0;
        wait_done(1, "R2");
        check(n_acc - base == 6, "R2", "access count unchanged", n_acc - base, 6);
        check(sexp.size() == 0 && dexp.size() == 0, "R2", "latched addresses used", sexp.size() + dexp.size(), 0);
        wr(4'hE, 32'h3);
        wr(4'h6, 32'h3);

        // zero counts
        base = n_acc;
        chan(1, 32'h6000, 0, 4, 0, 0, 1, 2, 0, 1, 0);
        repeat (2) @(negedge clk);
        check(dst_status == 3'b011, "R9", "zero length done+irq", dst_status, 3'b011);
        chan(0, 32'h6100, 4, 4, 0, 0, 0, 2, 1, 0, 0);
        repeat (2) @(negedge clk);
        check(src_status == 3'b001, "R9", "zero rows done", src_status, 3'b001);
        check(n_acc == base, "R9", "no access for zero count", n_acc - base, 0);
        wr(4'hE, 32'h3);
        wr(4'h6, 32'h3);

        // direction mismatch on each channel
        base = n_acc;
        chan(0, 32'h7000, 4, 4, 0, 0, 1, 2, 0, 1, 0);
        chan(1, 32'h7100, 4, 4, 0, 0, 0, 2, 0, 1, 0);
        repeat (5) @(negedge clk);
        check(src_status == 3'b000, "R10", "src mismatched enable ignored", src_status, 0);
        check(dst_status == 3'b000, "R10", "dst mismatched enable ignored", dst_status, 0);
        check(n_acc == base && mem_req == 1'b0, "R10", "no access", n_acc - base, 0);

        summary();
    end
endmodule